// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets software running on a small microcontroller reprogram its own flash. It sits on the core's special-function-register (SFR) bus as two byte-wide registers: a data register that supplies the byte to program, and a control register that selects the operation, selects the flash bank and holds a start flag. The flash target address comes in on a separate input port, because the address registers live elsewhere.

The start flag is protected. It can only be set by a control write that comes straight after the data register has received the key bytes 55h, AAh and 55h, in that order. When a protected start is accepted, the block captures the operation, bank, target address and data byte, and sends one request to the flash macro. It then holds the CPU stalled until the flash macro answers with a done pulse. At that point the start flag clears by itself, so the program carries on at the next instruction without polling.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset the data register and the control register both read 00h, `cpuStall` is low and `flReq` is low.
- R2: A write to SFR address F6h loads the data register. A read of F6h returns the last value written.
- R3: A read of control address F7h returns the start flag in bit 7, the bank select in bit 5 (1 = data flash, 0 = program flash) and the operation code in bits 1:0. Bits 6, 4, 3 and 2 always read 0. The operation codes are 00 = byte program, 01 = protect, 10 = 512-byte page erase and 11 = whole-array erase.
- R4: A control write with bit 7 set, without a completed unlock, leaves the start flag at 0, raises no flash request and does not stall the CPU. The bank and operation fields are still updated.
- R5: A control write with bit 7 set that directly follows the unlock keys 55h, AAh, 55h sets the start flag. In the next cycle `flReq` is high for exactly one cycle. `flOp`, `flBank` and `flAddr` carry the written operation code, the written bank bit and the `tgtAddr` value sampled at that write, and `flData` carries the data register's value. These latched values stay constant until the operation ends.
- R6: A data write that breaks the key order returns the unlock tracker to idle. A 55h that breaks the order counts as a fresh first key, so 55h, 55h, AAh, 55h unlocks, but 55h, AAh, AAh, 55h does not.
- R7: Any control write uses up the unlock, even one with bit 7 clear. A write to any SFR address other than F6h or F7h also cancels the unlock.
- R8: `cpuStall` and the start flag stay high from the launch until the clock edge that samples `flDone`, and both are low after that edge. With a done pulse N cycles after launch, the stall lasts exactly N cycles.
- R9: While an operation is in progress, control writes do not change the bank or operation fields, and neither control writes nor data writes change the latched flash outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrWe | input | 1 | SFR write strobe |
| sfrAddr | input | 8 | SFR address |
| sfrWdata | input | 8 | SFR write data |
| sfrRdata | output | 8 | SFR read data, combinational on `sfrAddr` |
| tgtAddr | input | 16 | Flash target address, sampled at launch |
| flReq | output | 1 | One-cycle flash operation request |
| flOp | output | 2 | Latched operation code |
| flBank | output | 1 | Latched bank select |
| flAddr | output | 16 | Latched target address |
| flData | output | 8 | Latched program byte |
| flDone | input | 1 | Flash completion pulse |
| cpuStall | output | 1 | Holds the CPU while an operation runs |

## Verification
A wrong unlock state shows up at the ports only at the next control write. That write either raises `flReq` and `cpuStall` one cycle later when it should not, or fails to raise them. Each broken, complete and cancelled key sequence is therefore followed at once by a start attempt. A wrong busy state shows up as a stall count that differs from the responder's latency, or as bank and operation fields that change after a write made during the stall. Both are checked on the cycle the done pulse is taken and on the readback that follows it.

// File: rtl/isp_pkg.sv
package isp_pkg;

  typedef enum logic [1:0] {
    OP_BYTE_PROG  = 2'b00,
    OP_PROTECT    = 2'b01,
    OP_PAGE_ERASE = 2'b10,
    OP_CHIP_ERASE = 2'b11
  } ispOp_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_KEY1  = 2'd1,
    UL_KEY2  = 2'd2,
    UL_ARMED = 2'd3
  } unlock_e;

  // strobes from control to datapath
  typedef struct packed {
    logic dataWr;   // data register write
    logic fieldWr;  // bank/op field write permitted
    logic launch;   // capture operands, start operation
  } ispStrobe_t;

  localparam int START_POS = 7;
  localparam int BANK_POS  = 5;
  localparam int OP_LSB    = 0;
  localparam int OP_W      = 2;

endpackage

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
#(
  parameter int          SFR_AW   = 8,
  parameter int          REG_W    = 8,
  parameter logic [7:0]  DATA_SFR = 8'hF6,
  parameter logic [7:0]  CTRL_SFR = 8'hF7,
  parameter logic [7:0]  KEY_A    = 8'h55,
  parameter logic [7:0]  KEY_B    = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWe,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [REG_W-1:0]  sfrWdata,
  input  logic              flDone,
  output ispStrobe_t        strobe,
  output logic              busy,
  output logic              flReq
);

  localparam logic [SFR_AW-1:0] DATA_A = SFR_AW'(DATA_SFR);
  localparam logic [SFR_AW-1:0] CTRL_A = SFR_AW'(CTRL_SFR);
  localparam logic [REG_W-1:0]  K1     = REG_W'(KEY_A);
  localparam logic [REG_W-1:0]  K2     = REG_W'(KEY_B);

  unlock_e ulState, ulNext;
  logic    dataHit, ctrlHit, otherHit, launch;

  assign dataHit  = sfrWe && (sfrAddr == DATA_A);
  assign ctrlHit  = sfrWe && (sfrAddr == CTRL_A);
  assign otherHit = sfrWe && !dataHit && !ctrlHit;

  // key sequence tracker
  always_comb begin
    ulNext = ulState;
    if (dataHit) begin
      unique case (ulState)
        UL_IDLE:  ulNext = (sfrWdata == K1) ? UL_KEY1 : UL_IDLE;
        UL_KEY1:  ulNext = (sfrWdata == K2) ? UL_KEY2 :
                           (sfrWdata == K1) ? UL_KEY1 : UL_IDLE;
        UL_KEY2:  ulNext = (sfrWdata == K1) ? UL_ARMED : UL_IDLE;
        UL_ARMED: ulNext = (sfrWdata == K1) ? UL_KEY1 : UL_IDLE;
        default:  ulNext = UL_IDLE;
      endcase
    end else if (ctrlHit || otherHit) begin
      ulNext = UL_IDLE;
    end
  end

  assign launch = ctrlHit && (ulState == UL_ARMED) && sfrWdata[START_POS] && !busy;

  always_comb begin
    strobe.dataWr  = dataHit;
    strobe.fieldWr = ctrlHit && !busy;
    strobe.launch  = launch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ulState <= UL_IDLE;
      busy    <= 1'b0;
      flReq   <= 1'b0;
    end else begin
      ulState <= ulNext;
      flReq   <= launch;
      if (launch)              busy <= 1'b1;
      else if (busy && flDone) busy <= 1'b0;
    end
  end

  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    flReq |=> !flReq);
  assert_req_in_op_R5: assert property (@(posedge clk) disable iff (!rstN)
    flReq |-> busy);
  assert_start_needs_key_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ulState == UL_ARMED && ctrlHit));
  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !flDone) |=> busy);
  assert_clear_on_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && flDone) |=> !busy);
  assert_unlock_consumed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit || otherHit) |=> (ulState == UL_IDLE));

endmodule

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         SFR_AW   = 8,
  parameter int         REG_W    = 8,
  parameter logic [7:0] DATA_SFR = 8'hF6,
  parameter logic [7:0] CTRL_SFR = 8'hF7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ispStrobe_t        strobe,
  input  logic              busy,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [REG_W-1:0]  sfrWdata,
  input  logic [ADDR_W-1:0] tgtAddr,
  output logic [REG_W-1:0]  sfrRdata,
  output logic [OP_W-1:0]   flOp,
  output logic              flBank,
  output logic [ADDR_W-1:0] flAddr,
  output logic [REG_W-1:0]  flData
);

  localparam logic [SFR_AW-1:0] DATA_A = SFR_AW'(DATA_SFR);
  localparam logic [SFR_AW-1:0] CTRL_A = SFR_AW'(CTRL_SFR);

  logic [REG_W-1:0] dataReg;
  logic [OP_W-1:0]  opReg;
  logic             bankReg;
  logic [REG_W-1:0] ctrlView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      opReg   <= '0;
      bankReg <= 1'b0;
      flOp    <= '0;
      flBank  <= 1'b0;
      flAddr  <= '0;
      flData  <= '0;
    end else begin
      if (strobe.dataWr) dataReg <= sfrWdata;
      if (strobe.fieldWr) begin
        opReg   <= sfrWdata[OP_LSB +: OP_W];
        bankReg <= sfrWdata[BANK_POS];
      end
      if (strobe.launch) begin
        flOp   <= sfrWdata[OP_LSB +: OP_W];
        flBank <= sfrWdata[BANK_POS];
        flAddr <= tgtAddr;
        flData <= dataReg;
      end
    end
  end

  always_comb begin
    ctrlView                      = '0;
    ctrlView[START_POS]           = busy;
    ctrlView[BANK_POS]            = bankReg;
    ctrlView[OP_LSB +: OP_W]      = opReg;
  end

  always_comb begin
    if (sfrAddr == DATA_A)      sfrRdata = dataReg;
    else if (sfrAddr == CTRL_A) sfrRdata = ctrlView;
    else                        sfrRdata = '0;
  end

  assert_fields_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(opReg) && $stable(bankReg)));
  assert_latch_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(flAddr) && $stable(flData) && $stable(flOp) && $stable(flBank)));

endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import isp_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         SFR_AW   = 8,
  parameter int         REG_W    = 8,
  parameter logic [7:0] DATA_SFR = 8'hF6,
  parameter logic [7:0] CTRL_SFR = 8'hF7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWe,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [REG_W-1:0]  sfrWdata,
  output logic [REG_W-1:0]  sfrRdata,
  input  logic [ADDR_W-1:0] tgtAddr,
  output logic              flReq,
  output logic [1:0]        flOp,
  output logic              flBank,
  output logic [ADDR_W-1:0] flAddr,
  output logic [REG_W-1:0]  flData,
  input  logic              flDone,
  output logic              cpuStall
);

  ispStrobe_t strobe;
  logic       busy;

  isp_ctrl #(
    .SFR_AW(SFR_AW), .REG_W(REG_W), .DATA_SFR(DATA_SFR), .CTRL_SFR(CTRL_SFR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .flDone(flDone), .strobe(strobe),
    .busy(busy), .flReq(flReq)
  );

  isp_datapath #(
    .ADDR_W(ADDR_W), .SFR_AW(SFR_AW), .REG_W(REG_W),
    .DATA_SFR(DATA_SFR), .CTRL_SFR(CTRL_SFR)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .sfrAddr(sfrAddr), .sfrWdata(sfrWdata), .tgtAddr(tgtAddr),
    .sfrRdata(sfrRdata), .flOp(flOp), .flBank(flBank),
    .flAddr(flAddr), .flData(flData)
  );

  assign cpuStall = busy;

endmodule

// File: tb/test_flash_isp_ctrl.sv
module test_flash_isp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'hF6;
  localparam logic [7:0] A_CTRL = 8'hF7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sfrWe = 1'b0;
  logic [7:0]  sfrAddr = 8'h00;
  logic [7:0]  sfrWdata = 8'h00;
  logic [7:0]  sfrRdata;
  logic [15:0] tgtAddr = 16'h0000;
  logic        flReq, flBank, flDone = 1'b0, cpuStall;
  logic [1:0]  flOp;
  logic [15:0] flAddr;
  logic [7:0]  flData;

  int nChecks = 0, nFail = 0, ulStage = 0;
  logic [7:0] expData = 8'h00, lastCtrl = 8'h00;
  logic [1:0] expOp = 2'b00;
  logic       expBank = 1'b0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_isp_ctrl i_flash_isp_ctrl (
    .clk(clk), .rstN(rstN), .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata), .tgtAddr(tgtAddr),
    .flReq(flReq), .flOp(flOp), .flBank(flBank), .flAddr(flAddr),
    .flData(flData), .flDone(flDone), .cpuStall(cpuStall)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // requirement model of the key tracker (R6)
  function automatic int ulStep(input int s, input logic [7:0] v);
    case (s)
      0: return (v == 8'h55) ? 1 : 0;
      1: return (v == 8'hAA) ? 2 : ((v == 8'h55) ? 1 : 0);
      2: return (v == 8'h55) ? 3 : 0;
      default: return (v == 8'h55) ? 1 : 0;
    endcase
  endfunction

  function automatic logic [7:0] ctrlExp(input logic st, input logic b, input logic [1:0] o);
    return {st, 1'b0, b, 3'b000, o};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfrWe = 1'b1; sfrAddr = a; sfrWdata = d;
    @(negedge clk);
    sfrWe = 1'b0; sfrAddr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfrAddr = a;
    #1;
    d = sfrRdata;
  endtask

  task automatic writeData(input logic [7:0] v);
    wr(A_DATA, v);
    ulStage = ulStep(ulStage, v);
    expData = v;
  endtask

  task automatic writeOther(input logic [7:0] v);
    logic [7:0] a;
    a = 8'h80 + 8'($urandom_range(0, 100));
    wr(a, v);
    ulStage = 0;
  endtask

  task automatic unlockKeys();
    writeData(8'h55); writeData(8'hAA); writeData(8'h55);
  endtask

  // control write; runs the operation to completion when expected to launch
  task automatic writeCtrl(input logic [7:0] v, input int lat, input bit poke,
                           input string tag);
    bit armed;
    logic [7:0] r;
    logic [7:0] heldData;
    int cnt;
    armed = (ulStage == 3);
    ulStage = 0;
    expOp = v[1:0]; expBank = v[5];
    lastCtrl = v;
    wr(A_CTRL, v);
    if (armed && v[7]) begin
      heldData = expData;
      chk(flReq == 1'b1, "R5", "flReq after launch", flReq, 1);
      chk(cpuStall == 1'b1, "R8", "stall after launch", cpuStall, 1);
      chk(flOp == expOp && flBank == expBank, "R5", "latched op/bank",
          {flBank, flOp}, {expBank, expOp});
      chk(flAddr == tgtAddr, "R5", "latched address", flAddr, tgtAddr);
      chk(flData == heldData, "R5", "latched data", flData, heldData);
      cnt = 1;
      for (int i = 1; i < lat; i++) begin
        if (poke && i == 1) begin sfrWe = 1'b1; sfrAddr = A_CTRL; sfrWdata = ~v | 8'h80; end
        if (poke && i == 2) begin sfrWe = 1'b1; sfrAddr = A_DATA; sfrWdata = 8'h3C; end
        @(negedge clk);
        sfrWe = 1'b0; sfrAddr = 8'h00;
        if (poke && i == 1) ulStage = 0;
        if (poke && i == 2) begin expData = 8'h3C; ulStage = ulStep(ulStage, 8'h3C); end
        if (i == 1) chk(flReq == 1'b0, "R5", "flReq one cycle", flReq, 0);
        if (cpuStall) cnt++;
      end
      if (poke) begin
        chk(flData == heldData && flOp == expOp && flBank == expBank, "R9",
            "latched outputs during op", {flBank, flOp, flData}, {expBank, expOp, heldData});
      end
      flDone = 1'b1;
      @(negedge clk);
      flDone = 1'b0;
      chk(cpuStall == 1'b0, "R8", "stall released at done", cpuStall, 0);
      chk(flReq == 1'b0, "R5", "flReq low after op", flReq, 0);
      chk(cnt == lat, "R8", "stall length", cnt, lat);
      rd(A_CTRL, r);
      chk(r == ctrlExp(1'b0, expBank, expOp), (poke ? "R9" : "R8"),
          "ctrl after op", r, ctrlExp(1'b0, expBank, expOp));
    end else begin
      chk(flReq == 1'b0 && cpuStall == 1'b0, tag, "no launch", {flReq, cpuStall}, 0);
      rd(A_CTRL, r);
      chk(r == ctrlExp(1'b0, expBank, expOp), "R3", "ctrl readback", r,
          ctrlExp(1'b0, expBank, expOp));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1 reset state, observed while reset held and after release
    chk(cpuStall == 1'b0 && flReq == 1'b0, "R1", "outputs in reset", {flReq, cpuStall}, 0);
    rstN = 1'b1;
    @(negedge clk);
    rd(A_DATA, r); chk(r == 8'h00, "R1", "data reg reset", r, 0);
    rd(A_CTRL, r); chk(r == 8'h00, "R1", "ctrl reg reset", r, 0);

    // R2 data register
    writeData(8'hC7); rd(A_DATA, r); chk(r == 8'hC7, "R2", "data readback", r, 8'hC7);

    // R3 unused bits read 0; R4 locked start
    writeCtrl(8'hFF, 1, 0, "R4");
    writeCtrl(8'h80, 1, 0, "R4");

    // R5 clean unlock, byte program on data bank
    tgtAddr = 16'h1234; writeData(8'h5A);
    unlockKeys();
    expData = 8'h55;
    writeCtrl(8'hA0, 3, 0, "R5");

    // R6 repeated first key then unlock
    tgtAddr = 16'hBEEF;
    writeData(8'h55); writeData(8'h55); writeData(8'hAA); writeData(8'h55);
    chk(ulStage == 3, "R6", "model armed", ulStage, 3);
    writeCtrl(8'h82, 1, 0, "R6");
    // R6 broken: 55 AA AA 55
    writeData(8'h55); writeData(8'hAA); writeData(8'hAA); writeData(8'h55);
    writeCtrl(8'h83, 1, 0, "R6");
    // R6 broken by a foreign byte in the middle
    writeData(8'h55); writeData(8'h12); writeData(8'hAA); writeData(8'h55);
    writeCtrl(8'h81, 1, 0, "R6");

    // R7 unlock consumed by a control write with bit 7 clear
    unlockKeys(); writeCtrl(8'h01, 1, 0, "R7"); writeCtrl(8'h81, 1, 0, "R7");
    // R7 other address write cancels
    unlockKeys(); writeOther(8'h80); writeCtrl(8'h83, 1, 0, "R7");

    // R9 writes while busy; R8 long stall
    tgtAddr = 16'h0200;
    unlockKeys(); writeCtrl(8'h82, 6, 1, "R9");
    rd(A_DATA, r); chk(r == 8'h3C, "R2", "data written during op", r, 8'h3C);

    // random mix
    for (int it = 0; it < 80; it++) begin
      int nd;
      logic [7:0] cv;
      nd = $urandom_range(0, 4);
      if ($urandom_range(0, 2) == 0) unlockKeys();
      for (int k = 0; k < nd; k++) begin
        case ($urandom_range(0, 3))
          0, 2: writeData(8'h55);
          1:    writeData(8'hAA);
          default: writeData(8'($urandom));
        endcase
      end
      if ($urandom_range(0, 5) == 0) writeOther(8'($urandom));
      rd(A_DATA, r); chk(r == expData, "R2", "random data readback", r, expData);
      tgtAddr = 16'($urandom);
      cv = 8'($urandom);
      if ($urandom_range(0, 3) != 0) cv[7] = 1'b1;
      writeCtrl(cv, $urandom_range(1, 6), $urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, "R4");
    end
    summary();
  end

endmodule